// File: doc/BRIEF.md
# Interrupt-Capable Parallel I/O Port

This block is an eight-pin general-purpose I/O port that sits on a simple address/data register bus. Software sets each pin on its own as an input or an output, writes the level driven on output pins, and reads back the pin levels after they have been brought into the clock domain. A per-pin function-select bit hands a pin's pad driver over to a peripheral signal in place of the port's own registers.

Every pin can also raise an event flag. A per-pin polarity bit chooses whether a rising or a falling edge sets the flag. A per-pin enable lets a flag reach the single combined interrupt request. Software clears a flag by writing zero to it. An edge that arrives in the same cycle as that write wins, so no event is lost.

Top module: `gpio_irq_port`

## Requirements
- R1: Reads return the register picked by `bus_addr` with no clock delay: 0 pin level, 1 output value, 2 direction, 3 function select, 4 event flags, 5 event enables, 6 edge polarity. Address 7 reads as zero. A write with `bus_wr` high stores `bus_wdata` at the next rising clock edge into the register at addresses 1, 2, 3, 5 or 6.
- R2: The pin-level register holds `pad_in` after two synchroniser flops, so a change on `pad_in` can be read after the second rising edge. Writes to address 0 change nothing.
- R3: For a pin whose function-select bit is 0, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its output-value bit.
- R4: For a pin whose function-select bit is 1, `pad_out` and `pad_oe` follow `periph_out` and `periph_oe`. `periph_in` always carries the synchronised pin level, whatever the function select holds.
- R5: With polarity bit 0, a rising synchronised level sets that pin's flag. With polarity bit 1, a falling level sets it. The flag becomes visible after the third rising edge following the `pad_in` change.
- R6: A write to address 4 loads the flags from `bus_wdata`, so writing 0 clears a flag. If an edge on the same pin is detected in that same cycle, the flag ends up set.
- R7: `irq` is high exactly when some pin has both its flag and its enable set. Writing all zeros to the enables drops `irq` on the next cycle.
- R8: After reset every register, including the flags and the synchroniser state, reads zero. So all pads are inputs and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Level driven to the pads |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| periph_out | input | 8 | Peripheral output per pin |
| periph_oe | input | 8 | Peripheral output enable per pin |
| periph_in | output | 8 | Synchronised pin level for the peripheral |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the collision of a flag-clearing write with a fresh edge on the same pin. The edge is only visible inside the block two edges after the pad moves, so the write has to land exactly in the third cycle. The stimulus changes `pad_in` just after a falling clock edge, waits two clock periods, and issues the clear write for one cycle. It then reads back that the flag stayed set. Random bus traffic mixed with random pad toggles also hits the same window, and a cycle-level model checks it there.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_DRIVE = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_ALT   = 3'd3,
    SEL_FLAG  = 3'd4,
    SEL_EN    = 3'd5,
    SEL_POL   = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  // polarity 0: rising edge, polarity 1: falling edge
  function automatic logic edge_event(input logic now_lvl, input logic old_lvl,
                                      input logic falling);
    return falling ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
  endfunction

  // next flag value: edge wins over a software write
  function automatic logic flag_next(input logic cur, input logic wr,
                                     input logic wbit, input logic hit);
    return hit | (wr ? wbit : cur);
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect import gpio_port_pkg::*; #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] falling_sel,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= '0;
    else        level_d <= level;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign hit[i] = edge_event(level[i], level_d[i], falling_sel[i]);
    end
  endgenerate
endmodule

// File: rtl/flag_bank.sv
module flag_bank import gpio_port_pkg::*; #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hit,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] enable,
  output logic [WIDTH-1:0] flag,
  output logic             irq
);
  logic [WIDTH-1:0] flag_d;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
      assign flag_d[i] = flag_next(flag[i], wr_en, wr_data[i], hit[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= flag_d;
  end

  assign irq = |(flag & enable);

  // every detected edge leaves its flag set, even against a clearing write
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flag & $past(hit)) == $past(hit)));

  // a flag only rises from an edge or from a write of 1
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(hit)
               & ~($past(wr_en) ? $past(wr_data) : '0)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port import gpio_port_pkg::*; #(
  parameter int unsigned PIN_COUNT   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [PIN_COUNT-1:0]  bus_wdata,
  output logic [PIN_COUNT-1:0]  bus_rdata,
  input  logic [PIN_COUNT-1:0]  pad_in,
  output logic [PIN_COUNT-1:0]  pad_out,
  output logic [PIN_COUNT-1:0]  pad_oe,
  input  logic [PIN_COUNT-1:0]  periph_out,
  input  logic [PIN_COUNT-1:0]  periph_oe,
  output logic [PIN_COUNT-1:0]  periph_in,
  output logic                  irq
);
  reg_sel_e sel;
  logic [PIN_COUNT-1:0] drive_q, dir_q, alt_q, en_q, pol_q;
  logic [PIN_COUNT-1:0] level, edge_hit, flag_q;
  logic flag_wr;

  assign sel     = reg_sel_e'(bus_addr);
  assign flag_wr = bus_wr && (sel == SEL_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= '0;
      alt_q   <= '0;
      en_q    <= '0;
      pol_q   <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DRIVE: drive_q <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_ALT:   alt_q   <= bus_wdata;
        SEL_EN:    en_q    <= bus_wdata;
        SEL_POL:   pol_q   <= bus_wdata;
        default:   ;
      endcase
    end
  end

  pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(level));

  edge_detect #(.WIDTH(PIN_COUNT)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .falling_sel(pol_q), .hit(edge_hit));

  flag_bank #(.WIDTH(PIN_COUNT)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(edge_hit), .wr_en(flag_wr),
    .wr_data(bus_wdata), .enable(en_q), .flag(flag_q), .irq(irq));

  generate
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pad
      assign pad_out[i] = alt_q[i] ? periph_out[i] : drive_q[i];
      assign pad_oe[i]  = alt_q[i] ? periph_oe[i]  : dir_q[i];
    end
  endgenerate

  assign periph_in = level;

  always_comb begin
    case (sel)
      SEL_LEVEL: bus_rdata = level;
      SEL_DRIVE: bus_rdata = drive_q;
      SEL_DIR:   bus_rdata = dir_q;
      SEL_ALT:   bus_rdata = alt_q;
      SEL_FLAG:  bus_rdata = flag_q;
      SEL_EN:    bus_rdata = en_q;
      SEL_POL:   bus_rdata = pol_q;
      default:   bus_rdata = '0;
    endcase
  end

  // cycles since reset, used so the delay check never looks before reset
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (level == $past(pad_in, 2)));
    end
  endgenerate

  // a direction write shows on the enables of I/O-owned pins next cycle
  assert_dir_to_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_DIR && alt_q == '0) |=> (pad_oe == $past(bus_wdata)));

  // clearing all enables removes the request next cycle
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_EN && bus_wdata == '0) |=> !irq);
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, periph_in;
  logic [7:0] periph_out = '0, periph_oe = '0;
  logic       irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
    .periph_oe(periph_oe), .periph_in(periph_in), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_s1 = 0, m_s2 = 0, m_old = 0;
  logic [7:0] m_drv = 0, m_dir = 0, m_alt = 0, m_flag = 0, m_en = 0, m_pol = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_old <= 0;
      m_drv <= 0; m_dir <= 0; m_alt <= 0; m_flag <= 0; m_en <= 0; m_pol <= 0;
    end else begin
      logic [7:0] seen;
      seen = (m_s2 ^ m_old) & (m_s2 ^ m_pol);
      m_s1 <= pad_in; m_s2 <= m_s1; m_old <= m_s2;
      if (bus_wr && bus_addr == 3'd4) m_flag <= bus_wdata | seen;
      else                            m_flag <= m_flag | seen;
      if (bus_wr) begin
        if (bus_addr == 3'd1) m_drv <= bus_wdata;
        if (bus_addr == 3'd2) m_dir <= bus_wdata;
        if (bus_addr == 3'd3) m_alt <= bus_wdata;
        if (bus_addr == 3'd5) m_en  <= bus_wdata;
        if (bus_addr == 3'd6) m_pol <= bus_wdata;
      end
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    logic [7:0] v [8];
    v[0] = m_s2; v[1] = m_drv; v[2] = m_dir; v[3] = m_alt;
    v[4] = m_flag; v[5] = m_en; v[6] = m_pol; v[7] = 8'h00;
    return v[a];
  endfunction

  bit model_on = 1'b0;
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R1 model rdata", bus_rdata, m_read(bus_addr));
      chk("R3 model pad_out", pad_out, (m_alt & periph_out) | (~m_alt & m_drv));
      chk("R3 model pad_oe", pad_oe, (m_alt & periph_oe) | (~m_alt & m_dir));
      chk("R4 model periph_in", periph_in, m_s2);
      chk("R7 model irq", irq, (m_flag & m_en) != 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    #1;
  endtask

  task automatic run_all();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    model_on = 1'b1;
    // R8 reset values
    for (int a = 0; a < 7; a++) rd_chk("R8 reset reg", a[2:0], 8'h00);
    chk("R8 reset irq", irq, 0);
    chk("R8 reset pad_oe", pad_oe, 8'h00);
    // R1, R3 plain I/O
    wr(3'd1, 8'hA5); wr(3'd2, 8'h0F);
    rd_chk("R1 drive readback", 3'd1, 8'hA5);
    rd_chk("R1 dir readback", 3'd2, 8'h0F);
    chk("R3 pad_out", pad_out, 8'hA5);
    chk("R3 pad_oe", pad_oe, 8'h0F);
    rd_chk("R1 unused address", 3'd7, 8'h00);
    // R2 synchroniser delay and read-only level
    bus_addr = 3'd0; pad_in = 8'h3C;
    @(negedge clk); chk("R2 level after one edge", bus_rdata, 8'h00); #1;
    @(negedge clk); chk("R2 level after two edges", bus_rdata, 8'h3C); #1;
    // R5 rising flags (third edge)
    bus_addr = 3'd4;
    @(negedge clk); chk("R5 rising flags", bus_rdata, 8'h3C); #1;
    chk("R7 irq masked", irq, 0);
    wr(3'd0, 8'hFF);
    rd_chk("R2 write to level ignored", 3'd0, 8'h3C);
    wr(3'd5, 8'h04);
    chk("R7 irq enabled", irq, 1);
    // R4 function select
    periph_out = 8'hAA; periph_oe = 8'hCC;
    wr(3'd3, 8'hF0);
    chk("R4 pad_out mux", pad_out, 8'hA5);
    chk("R4 pad_oe mux", pad_oe, 8'hCF);
    chk("R4 periph_in", periph_in, 8'h3C);
    // R6 clear, R5 falling
    wr(3'd4, 8'h00);
    rd_chk("R6 flags cleared", 3'd4, 8'h00);
    chk("R7 irq after clear", irq, 0);
    wr(3'd6, 8'hFF);
    pad_in = 8'h01;
    repeat (3) tick();
    rd_chk("R5 falling flags", 3'd4, 8'h3C);
    wr(3'd5, 8'h00);
    chk("R7 irq after enables off", irq, 0);
    // R6 collision of clear and edge
    wr(3'd4, 8'h00); wr(3'd6, 8'h00);
    pad_in = 8'h03;
    tick(); tick();
    wr(3'd4, 8'h00);
    rd_chk("R6 edge beats clear", 3'd4, 8'h02);
    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      bus_addr   = 3'($urandom_range(0, 7));
      bus_wdata  = 8'($urandom);
      bus_wr     = ($urandom_range(0, 3) == 0);
      periph_out = 8'($urandom);
      periph_oe  = 8'($urandom);
      if ($urandom_range(0, 2) == 0) pad_in = pad_in ^ 8'($urandom);
      tick();
    end
    bus_wr = 1'b0;
    tick();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule